// File: doc/BRIEF.md
# LED Pixel FIFO and Interrupt Front-End

This block sits between a simple register bus and the serial bitstream encoder of an addressable LED chain. Software (or a DMA engine) writes 32-bit pixel words into a data register. Each write lands in a 32-entry first-in first-out buffer that the encoder drains through a valid/pop handshake. A programmable trigger level drives two things: a DMA request line, and a CPU refill event in the interrupt status. An interrupt output combines the refill event and a transfer-finished event under per-source enables and a global enable.

A two-state sequencer follows the encoder. In `XS_IDLE` the block waits. The transition `IDLE->ACTIVE` is taken on an `xfer_start` pulse, and that pulse also empties the buffer. In `XS_ACTIVE` the refill event is raised whenever the fill level is at or below the trigger level. An `xfer_start` in `XS_ACTIVE` takes `ACTIVE->ACTIVE`: the buffer is emptied again and the transfer restarts. An `xfer_done` pulse without a start takes `ACTIVE->IDLE` and raises the finished event. The status register holds both events as write-one-to-clear bits and also shows the live fill level.

Register word indices on `bus_addr`: 0 is the pixel data port (write only, reads 0), 1 is DMA control, 2 is interrupt enables, 3 is status.

Top module: `led_pixel_frontend`

## Requirements
- R1: After reset every register reads 0, the fill level is 0, and `irq`, `dma_req` and `px_valid` are low.
- R2: Each bus write to index 0 pushes `bus_wdata` as one entry. Entries leave on `px_data` in write order, with `px_valid` high while the buffer is not empty. Status bits 15:10 always show the current entry count, from 0 to 32.
- R3: A write to index 0 while 32 entries are held is dropped. The level stays 32 and the stored entries come out unchanged.
- R4: DMA control (index 1) stores the DMA enable in bit 5 and a 5-bit trigger level in bits 4:0. These bits read back as written and all other bits read 0.
- R5: Interrupt enables (index 2) store the global enable in bit 5, the refill enable in bit 1 and the finished enable in bit 0. These bits read back as written and all other bits read 0.
- R6: An `xfer_start` pulse empties the buffer (level 0 one cycle later) and puts the sequencer in `XS_ACTIVE`.
- R7: Status bit 1 (refill event) becomes set at the clock edge where the sequencer is in `XS_ACTIVE` and level <= trigger level. It is never set in `XS_IDLE`.
- R8: `xfer_done` in `XS_ACTIVE` sets status bit 0 (finished event) at that edge and returns to `XS_IDLE`. `xfer_done` in `XS_IDLE` has no effect.
- R9: Writing status with a bit at 1 clears that event and a 0 leaves it. If a set condition holds at the same edge, the set wins.
- R10: `irq` = global enable AND ((finished event AND finished enable) OR (refill event AND refill enable)).
- R11: `dma_req` is high exactly when the DMA enable is set and (32 - level) >= trigger level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| xfer_start | input | 1 | Encoder begins a transfer (one-cycle pulse) |
| xfer_done | input | 1 | Encoder finished a transfer (one-cycle pulse) |
| px_valid | output | 1 | Buffer holds at least one entry |
| px_data | output | 32 | Oldest buffered entry |
| px_pop | input | 1 | Encoder consumes `px_data` |
| dma_req | output | 1 | DMA refill request |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples `bus_we`. Readback, the level field, `px_data` and `px_valid` are valid at the following falling edge. The refill and finished events need one more edge after their condition appears, so the bench waits two full cycles after changing the level or sending a pulse before it reads the status. `dma_req` and `irq` are combinational on registered state. They are sampled at the falling edge that follows the write or push that changed their inputs. All inputs are driven and all outputs are sampled on falling edges.

// File: rtl/led_fe_pkg.sv
package led_fe_pkg;

    typedef enum logic [1:0] {
        RA_PIXEL  = 2'd0,
        RA_DMA    = 2'd1,
        RA_IRQEN  = 2'd2,
        RA_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        XS_IDLE   = 1'b0,
        XS_ACTIVE = 1'b1
    } xfer_state_e;

    localparam int unsigned GIE_BIT = 5;
    localparam int unsigned REQ_BIT = 1;
    localparam int unsigned FIN_BIT = 0;
    localparam int unsigned LVL_LSB = 10;

endpackage

// File: rtl/led_fe_fifo.sv
module led_fe_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [LVL_W-1:0]  count;
    logic              full, do_push, do_pop;

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;

    generate
        if (DEPTH == (1 << PTR_W)) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            count <= count + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign level   = count;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));
    p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == LVL_W'(DEPTH)));
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/led_fe_seq.sv
module led_fe_seq
    import led_fe_pkg::*;
#(
    parameter int unsigned LVL_W  = 6,
    parameter int unsigned TRIG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    input  logic [LVL_W-1:0]  level,
    input  logic [TRIG_W-1:0] trig,
    output logic              flush,
    output logic              req_set,
    output logic              fin_set
);

    xfer_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        flush     = start;
        req_set   = 1'b0;
        fin_set   = 1'b0;
        unique case (state)
            XS_IDLE: begin
                if (start) state_nxt = XS_ACTIVE;
            end
            XS_ACTIVE: begin
                req_set = (level <= LVL_W'(trig));
                fin_set = done;
                if (done && !start) state_nxt = XS_IDLE;
            end
            default: state_nxt = XS_IDLE;
        endcase
    end

    p_start_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == XS_ACTIVE));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_ACTIVE && done && !start) |=> (state == XS_IDLE));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_IDLE && !start) |=> (state == XS_IDLE));

endmodule

// File: rtl/led_fe_regs.sv
module led_fe_regs
    import led_fe_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LVL_W  = 6,
    parameter int unsigned TRIG_W = 5,
    localparam int unsigned DMA_EN_BIT = TRIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LVL_W-1:0]  level,
    input  logic              fin_set,
    input  logic              req_set,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              dma_en,
    output logic [TRIG_W-1:0] trig,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic gie, req_en, fin_en;
    logic sts_fin, sts_req;
    logic clr_fin, clr_req;

    assign push      = we && (addr == RA_PIXEL);
    assign push_data = wdata;
    assign clr_fin   = we && (addr == RA_STATUS) && wdata[FIN_BIT];
    assign clr_req   = we && (addr == RA_STATUS) && wdata[REQ_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en  <= 1'b0;
            trig    <= '0;
            gie     <= 1'b0;
            req_en  <= 1'b0;
            fin_en  <= 1'b0;
            sts_fin <= 1'b0;
            sts_req <= 1'b0;
        end else begin
            if (we && addr == RA_DMA) begin
                dma_en <= wdata[DMA_EN_BIT];
                trig   <= wdata[TRIG_W-1:0];
            end
            if (we && addr == RA_IRQEN) begin
                gie    <= wdata[GIE_BIT];
                req_en <= wdata[REQ_BIT];
                fin_en <= wdata[FIN_BIT];
            end
            sts_fin <= (sts_fin & ~clr_fin) | fin_set;
            sts_req <= (sts_req & ~clr_req) | req_set;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_DMA: begin
                rdata[DMA_EN_BIT]   = dma_en;
                rdata[TRIG_W-1:0]   = trig;
            end
            RA_IRQEN: begin
                rdata[GIE_BIT] = gie;
                rdata[REQ_BIT] = req_en;
                rdata[FIN_BIT] = fin_en;
            end
            RA_STATUS: begin
                rdata[LVL_LSB +: LVL_W] = level;
                rdata[REQ_BIT]          = sts_req;
                rdata[FIN_BIT]          = sts_fin;
            end
            default: rdata = '0;
        endcase
    end

    assign irq = gie & ((sts_fin & fin_en) | (sts_req & req_en));

    p_fin_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_set |=> sts_fin);
    p_req_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_set |=> sts_req);
    p_req_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_req) |-> $past(req_set));
    p_w1c_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fin && !fin_set) |=> !sts_fin);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_fin && !sts_req) |-> !irq);

endmodule

// File: rtl/led_pixel_frontend.sv
module led_pixel_frontend #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
    localparam int unsigned TRIG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_start,
    input  logic              xfer_done,
    output logic              px_valid,
    output logic [DATA_W-1:0] px_data,
    input  logic              px_pop,
    output logic              dma_req,
    output logic              irq
);

    logic              flush, push, req_set, fin_set, dma_en, empty;
    logic [DATA_W-1:0] push_data;
    logic [LVL_W-1:0]  level, free;
    logic [TRIG_W-1:0] trig;

    led_fe_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W), .TRIG_W(TRIG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .level(level), .fin_set(fin_set), .req_set(req_set), .push(push),
        .push_data(push_data), .dma_en(dma_en), .trig(trig), .rdata(bus_rdata),
        .irq(irq)
    );

    led_fe_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_data(push_data),
        .pop(px_pop), .rd_data(px_data), .level(level), .empty(empty)
    );

    led_fe_seq #(.LVL_W(LVL_W), .TRIG_W(TRIG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .done(xfer_done),
        .level(level), .trig(trig), .flush(flush), .req_set(req_set),
        .fin_set(fin_set)
    );

    assign px_valid = ~empty;
    assign free     = LVL_W'(DEPTH) - level;
    assign dma_req  = dma_en && (free >= LVL_W'(trig));

    p_dma_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH) && trig != '0) |-> !dma_req);
    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (level != '0));

endmodule

// File: tb/sim_led_pixel_frontend.sv
module sim_led_pixel_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xfer_start = 1'b0;
    logic        xfer_done = 1'b0;
    logic        px_valid;
    logic [31:0] px_data;
    logic        px_pop = 1'b0;
    logic        dma_req;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    led_pixel_frontend u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_start(xfer_start),
        .xfer_done(xfer_done), .px_valid(px_valid), .px_data(px_data),
        .px_pop(px_pop), .dma_req(dma_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk); px_pop = 1'b1;
        @(negedge clk); px_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 dma_req", {31'd0, dma_req}, 0);
        chk("R1 px_valid", {31'd0, px_valid}, 0);

        // R4 DMA control readback sweep
        for (int k = 0; k < 64; k++) begin
            wr(2'd1, 32'hFFFF_FFC0 | 32'(k));
            rd(2'd1, v); chk("R4 dma ctrl", v, 32'(k));
        end

        // R5 interrupt enable readback
        for (int k = 0; k < 8; k++) begin
            logic [31:0] e;
            e = (32'(k[2]) << 5) | (32'(k[1]) << 1) | 32'(k[0]);
            wr(2'd2, 32'hFFFF_FFDC | e);
            rd(2'd2, v); chk("R5 irq en", v, e);
        end
        wr(2'd2, 32'h0);

        // R11 / R2 / R3 / R6 : DMA request sweep over trigger and level
        for (int t = 0; t < 32; t++) begin
            wr(2'd1, 32'h20 | 32'(t));
            pulse_start();
            rd(2'd3, v); chk("R6 flush level", (v >> 10) & 32'h3F, 0);
            for (int l = 0; l <= 32; l++) begin
                rd(2'd3, v); chk("R2 level", (v >> 10) & 32'h3F, 32'(l));
                chk("R11 dma_req", {31'd0, dma_req}, {31'd0, ((32 - l) >= t)});
                if (l < 32) wr(2'd0, 32'(l));
            end
            wr(2'd0, 32'hBAD0_0000);
            rd(2'd3, v); chk("R3 level held", (v >> 10) & 32'h3F, 32);
            pulse_done();
            wr(2'd3, 32'h3);
        end
        // R11 disabled
        wr(2'd1, 32'h00);
        pulse_start();
        chk("R11 dma off", {31'd0, dma_req}, 0);

        // R2 / R3 ordering and drop when full
        for (int i = 0; i < 32; i++) wr(2'd0, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
        for (int i = 0; i < 3; i++) wr(2'd0, 32'hDEAD_0000 + 32'(i));
        rd(2'd3, v); chk("R3 full level", (v >> 10) & 32'h3F, 32);
        for (int i = 0; i < 32; i++) begin
            chk("R2 px_valid", {31'd0, px_valid}, 1);
            chk("R3 order data", px_data, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
            pop1();
        end
        chk("R2 empty valid", {31'd0, px_valid}, 0);
        rd(2'd3, v); chk("R2 empty level", (v >> 10) & 32'h3F, 0);
        pulse_done();
        wr(2'd3, 32'h3);

        // R7 refill event sweep (active)
        for (int t = 0; t < 32; t += 5) begin
            for (int l = 0; l <= 32; l += 3) begin
                wr(2'd1, 32'(t));
                pulse_start();
                for (int i = 0; i < l; i++) wr(2'd0, 32'(i));
                idle(2);
                wr(2'd3, 32'h2);
                idle(2);
                rd(2'd3, v); chk("R7 refill", (v >> 1) & 32'h1, {31'd0, (l <= t)});
            end
        end
        pulse_done();
        wr(2'd3, 32'h3);
        idle(3);
        rd(2'd3, v); chk("R7 idle no refill", v & 32'h3, 0);

        // R8 finished event
        pulse_done();
        idle(2);
        rd(2'd3, v); chk("R8 done idle ignored", v & 32'h3, 0);
        wr(2'd1, 32'h0);
        pulse_start();
        for (int i = 0; i < 4; i++) wr(2'd0, 32'(i));
        idle(1);
        wr(2'd3, 32'h2);
        pulse_done();
        idle(2);
        rd(2'd3, v); chk("R8 fin set", v & 32'h1, 1);
        // R9 write 0 keeps, write 1 clears
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R9 zero keeps", v & 32'h1, 1);
        wr(2'd3, 32'h1);
        rd(2'd3, v); chk("R9 one clears", v & 32'h1, 0);
        // R9 set wins over clear
        wr(2'd1, 32'd31);
        pulse_start();
        idle(2);
        wr(2'd3, 32'h2);
        rd(2'd3, v); chk("R9 set wins", (v >> 1) & 32'h1, 1);
        pulse_done();
        idle(2);

        // R10 irq combinations; now idle, fin=1 req=1
        for (int c = 0; c < 4; c++) begin
            logic ef, er;
            unique case (c)
                0: begin ef = 1; er = 1; end
                1: begin wr(2'd3, 32'h2); ef = 1; er = 0; end
                2: begin pulse_start(); idle(2); wr(2'd3, 32'h1); ef = 0; er = 1; end
                default: begin pulse_done(); idle(1); wr(2'd3, 32'h3); ef = 0; er = 0; end
            endcase
            rd(2'd3, v); chk("R10 status", v & 32'h3, {30'd0, er, ef});
            for (int k = 0; k < 8; k++) begin
                wr(2'd2, (32'(k[2]) << 5) | (32'(k[1]) << 1) | 32'(k[0]));
                chk("R10 irq", {31'd0, irq},
                    {31'd0, k[2] & ((k[0] & ef) | (k[1] & er))});
            end
        end

        summary();
        $finish;
    end

endmodule